// File: doc/BRIEF.md
# Coherent Calendar Shadow Reader

This block sits between a running calendar and a processor bus. It keeps three shadow copies of the calendar: a binary sub-second count, a time word and a date word. The calendar domain refreshes these copies. Software reads them through a small register port and always gets one consistent instant, even though each read returns only one word.

The copies are taken on a refresh pulse, which arrives already synchronised to the bus clock. A read of the sub-second word or the time word freezes the copies. They stay frozen until software reads the date word, so the words that belong together cannot drift apart during a read. A sync flag reports that the copies were freshly loaded. Software can clear it and then wait for it to return before it reads again.

Top module: `cal_shadow_reader`

## Requirements
- R1: After a synchronous active-low reset, the read data, all three copies, the sync flag and the freeze state are all zero.
- R2: A read strobe with address A presents the selected word on the read data one clock later. The read data holds its value while no read is issued.
- R3: A refresh pulse with no freeze active, and no freezing read in the same cycle, loads all three copies in that one cycle. The sub-second copy is the input zero-extended to 32 bits.
- R4: Bits the layouts do not define read as zero. The time word keeps bits 3:0 seconds units, 6:4 seconds tens, 11:8 minutes units, 14:12 minutes tens, 19:16 hours units, 21:20 hours tens and 22 PM. The date word keeps bits 3:0 day units, 5:4 day tens, 11:8 month units, 12 month tens, 15:13 weekday, 19:16 year units and 23:20 year tens.
- R5: A read of address 0 (sub-second) or 1 (time) starts the freeze. From that cycle on, refresh pulses leave the copies unchanged.
- R6: A read of address 2 (date) ends the freeze. The first refresh pulse in a later cycle loads all three copies.
- R7: The sync flag becomes 1 in the cycle after a refresh is applied. A refresh that the freeze blocks does not set it.
- R8: A write to address 3 with bit 0 equal to 0 clears the sync flag. A write with bit 0 equal to 1 has no effect. An applied refresh in the same cycle wins, and the flag stays 1.
- R9: Writes to addresses 0, 1 and 2 are ignored, and the copies are unchanged.
- R10: A read of address 3 returns the sync flag in bit 0 and the freeze state in bit 1, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| refresh_i | input | 1 | One-cycle refresh pulse from the calendar domain |
| live_subsec_i | input | SUBSEC_W | Live sub-second count |
| live_time_i | input | 32 | Live time word |
| live_date_i | input | 32 | Live date word |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Word address: 0 sub-second, 1 time, 2 date, 3 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| sync_flag_o | output | 1 | Sync flag |

## Verification
The main sweep runs every sequence of three cycles built from nine bus operations: idle, four reads, two status writes and two writes to read-only words. Each cycle is tried with and without a refresh. A read-order model in the bench separates a refresh that was rightly blocked from one that was lost, and a clear that beats a refresh from one that loses to it. The live inputs change every cycle, so a copy taken one cycle early or late shows up as a wrong word. A directed pass with all-ones inputs exposes any undefined bit that leaks through the masks.

// File: rtl/cal_shadow_pkg.sv
// Shared constants for the calendar shadow reader.
// Assumes 32-bit bus words and a two-bit word address.
package cal_shadow_pkg;

    localparam int WORD_W     = 32;
    localparam int NUM_SHADOW = 3;
    localparam int ADDR_W     = 2;

    // Word select on the bus port
    typedef enum logic [ADDR_W-1:0] {
        SEL_SUBSEC = 2'd0,
        SEL_TIME   = 2'd1,
        SEL_DATE   = 2'd2,
        SEL_STATUS = 2'd3
    } sel_e;

    // Defined bits of the time and date layouts
    localparam logic [WORD_W-1:0] TIME_KEEP = 32'h007F_7F7F;
    localparam logic [WORD_W-1:0] DATE_KEEP = 32'h00FF_FF3F;

    localparam int STAT_FLAG_BIT = 0;
    localparam int STAT_LOCK_BIT = 1;

    // Keep mask of shadow word idx for a given sub-second width
    function automatic logic [WORD_W-1:0] keep_mask(input int idx, input int sub_w);
        logic [WORD_W-1:0] m;
        m = '0;
        case (idx)
            0: for (int b = 0; b < WORD_W; b++) m[b] = (b < sub_w);
            1: m = TIME_KEEP;
            default: m = DATE_KEEP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cal_shadow_bank.sv
// Holds the three shadow words. When apply_i is high, all three words load
// from the live inputs in the same cycle, masked to their defined bits.
// Assumes apply_i is already qualified by the freeze logic.
module cal_shadow_bank
    import cal_shadow_pkg::*;
#(
    parameter int SUBSEC_W = 16
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         apply_i,
    input  logic [SUBSEC_W-1:0]          live_subsec_i,
    input  logic [WORD_W-1:0]            live_time_i,
    input  logic [WORD_W-1:0]            live_date_i,
    output logic [NUM_SHADOW*WORD_W-1:0] shadow_o
);

    logic [NUM_SHADOW*WORD_W-1:0] live_flat;

    // Gather the live words in address order
    assign live_flat = {live_date_i, live_time_i, WORD_W'(live_subsec_i)};

    for (genvar gi = 0; gi < NUM_SHADOW; gi++) begin : g_word
        localparam logic [WORD_W-1:0] KEEP = keep_mask(gi, SUBSEC_W);
        logic [WORD_W-1:0] word_q;

        // Load one shadow word when a refresh is applied
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                word_q <= '0;
            end else if (apply_i) begin
                word_q <= live_flat[gi*WORD_W +: WORD_W] & KEEP;
            end
        end

        assign shadow_o[gi*WORD_W +: WORD_W] = word_q;
    end

endmodule

// File: rtl/cal_shadow_lock.sv
// Freeze and sync-flag control. A read of the sub-second or time word freezes
// the shadows; a read of the date word thaws them. A refresh applies only when
// no freeze is active or starting. Assumes refresh_i is a one-cycle pulse.
module cal_shadow_lock
    import cal_shadow_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              refresh_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wbit_i,
    output logic              apply_o,
    output logic              lock_o,
    output logic              flag_o
);

    logic lock_q;
    logic flag_q;
    logic lock_req;
    logic lock_rel;
    logic flag_clr;

    // Decode the bus events that touch the freeze and the flag
    always_comb begin
        lock_req = rd_en_i && ((addr_i == SEL_SUBSEC) || (addr_i == SEL_TIME));
        lock_rel = rd_en_i && (addr_i == SEL_DATE);
        flag_clr = wr_en_i && (addr_i == SEL_STATUS) && !wbit_i;
        apply_o  = refresh_i && !lock_q && !lock_req;
    end

    // Track the freeze state
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lock_q <= 1'b0;
        end else if (lock_req) begin
            lock_q <= 1'b1;
        end else if (lock_rel) begin
            lock_q <= 1'b0;
        end
    end

    // Track the sync flag; an applied refresh wins over a clear
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else if (apply_o) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign lock_o = lock_q;
    assign flag_o = flag_q;

endmodule

// File: rtl/cal_shadow_rdport.sv
// Registered read multiplexer over the shadows and the status word.
// Assumes read data holds its value between reads.
module cal_shadow_rdport
    import cal_shadow_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         rd_en_i,
    input  logic [ADDR_W-1:0]            addr_i,
    input  logic [NUM_SHADOW*WORD_W-1:0] shadow_i,
    input  logic                         lock_i,
    input  logic                         flag_i,
    output logic [WORD_W-1:0]            rdata_o
);

    logic [WORD_W-1:0] status_w;
    logic [WORD_W-1:0] pick_w;
    logic [WORD_W-1:0] rdata_q;

    // Build the status word and select the addressed word
    always_comb begin
        status_w = '0;
        status_w[STAT_FLAG_BIT] = flag_i;
        status_w[STAT_LOCK_BIT] = lock_i;
        if (addr_i == SEL_STATUS) begin
            pick_w = status_w;
        end else begin
            pick_w = shadow_i[32'(addr_i)*WORD_W +: WORD_W];
        end
    end

    // Capture read data on a read strobe
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            rdata_q <= pick_w;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/cal_shadow_reader.sv
// Top of the calendar shadow reader. It ties the shadow bank, the freeze and
// flag control and the read port together. Assumes all inputs are in the bus
// clock domain.
module cal_shadow_reader
    import cal_shadow_pkg::*;
#(
    parameter int SUBSEC_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                refresh_i,
    input  logic [SUBSEC_W-1:0] live_subsec_i,
    input  logic [31:0]         live_time_i,
    input  logic [31:0]         live_date_i,
    input  logic                rd_en_i,
    input  logic                wr_en_i,
    input  logic [1:0]          addr_i,
    input  logic [31:0]         wdata_i,
    output logic [31:0]         rdata_o,
    output logic                sync_flag_o
);

    logic                         apply_w;
    logic                         lock_w;
    logic                         flag_w;
    logic [NUM_SHADOW*WORD_W-1:0] shadow_w;

    cal_shadow_lock u_lock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .refresh_i (refresh_i),
        .rd_en_i   (rd_en_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wbit_i    (wdata_i[STAT_FLAG_BIT]),
        .apply_o   (apply_w),
        .lock_o    (lock_w),
        .flag_o    (flag_w)
    );

    cal_shadow_bank #(.SUBSEC_W(SUBSEC_W)) u_bank (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .apply_i       (apply_w),
        .live_subsec_i (live_subsec_i),
        .live_time_i   (live_time_i),
        .live_date_i   (live_date_i),
        .shadow_o      (shadow_w)
    );

    cal_shadow_rdport u_rd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .shadow_i (shadow_w),
        .lock_i   (lock_w),
        .flag_i   (flag_w),
        .rdata_o  (rdata_o)
    );

    assign sync_flag_o = flag_w;

endmodule

// File: rtl/cal_shadow_checker.sv
// Temporal checks on the shadow reader, bound into the top module.
module cal_shadow_checker
    import cal_shadow_pkg::*;
(
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         refresh_i,
    input logic                         rd_en_i,
    input logic                         wr_en_i,
    input logic [1:0]                   addr_i,
    input logic                         wbit_i,
    input logic                         lock_i,
    input logic                         flag_i,
    input logic [NUM_SHADOW*WORD_W-1:0] shadow_i
);

    assert_frozen_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_i && refresh_i) |=> $stable(shadow_i));

    assert_freeze_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && (addr_i == 2'd0 || addr_i == 2'd1)) |=> lock_i);

    assert_thaw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && addr_i == 2'd2) |=> !lock_i);

    assert_flag_source_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_i) |-> ($past(refresh_i) && !$past(lock_i)));

    assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 2'd3 && !wbit_i && !refresh_i) |=> !flag_i);

    assert_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i != 2'd3 && !refresh_i) |=> $stable(shadow_i));

    assert_undefined_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((shadow_i[WORD_W +: WORD_W] & ~TIME_KEEP) == '0) &&
        ((shadow_i[2*WORD_W +: WORD_W] & ~DATE_KEEP) == '0));

endmodule

bind cal_shadow_reader cal_shadow_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .refresh_i (refresh_i),
    .rd_en_i   (rd_en_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wbit_i    (wdata_i[0]),
    .lock_i    (lock_w),
    .flag_i    (flag_w),
    .shadow_i  (shadow_w)
);

// File: tb/sim_cal_shadow_reader.sv
module sim_cal_shadow_reader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        refresh = 1'b0;
    logic [15:0] lv_sub = '0;
    logic [31:0] lv_time = '0;
    logic [31:0] lv_date = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sync_flag;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    int wd   = 0;
    bit all_ones = 1'b0;

    // Bench model state
    logic [31:0] m_sub = '0, m_time = '0, m_date = '0, m_rd = '0;
    logic        m_lock = 1'b0, m_flag = 1'b0;

    always #4 clk = ~clk;

    cal_shadow_reader #(.SUBSEC_W(16)) u0 (
        .clk_i (clk), .rst_ni (rst_n), .refresh_i (refresh),
        .live_subsec_i (lv_sub), .live_time_i (lv_time), .live_date_i (lv_date),
        .rd_en_i (rd_en), .wr_en_i (wr_en), .addr_i (addr), .wdata_i (wdata),
        .rdata_o (rdata), .sync_flag_o (sync_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // op: 0 idle, 1..4 read addr op-1, 5 status write bit0=0, 6 status write bit0=1,
    //     7 write time word, 8 write sub-second word
    task automatic step(input int op, input bit rfr, input string tag);
        logic        rd_lock, apply;
        string       rtag, ftag;
        @(negedge clk);
        cyc++;
        rd_en = (op >= 1 && op <= 4);
        wr_en = (op >= 5);
        addr  = (op >= 1 && op <= 4) ? 2'(op - 1) : (op == 7) ? 2'd1 : (op == 8) ? 2'd0 : 2'd3;
        wdata = (op == 6 || op == 7) ? 32'hFFFF_FFFF : 32'h0;
        refresh = rfr;
        if (all_ones) begin
            lv_sub = 16'hFFFF; lv_time = '1; lv_date = '1;
        end else begin
            lv_sub  = 16'(cyc * 7 + 3);
            lv_time = 32'(cyc) * 32'h9E37_79B1;
            lv_date = ~lv_time ^ (32'(cyc) << 5);
        end
        // model of the next state
        if (rd_en) begin
            case (addr)
                2'd0: m_rd = m_sub;
                2'd1: m_rd = m_time;
                2'd2: m_rd = m_date;
                default: m_rd = {30'b0, m_lock, m_flag};
            endcase
        end
        rd_lock = rd_en && (addr <= 2'd1);
        apply   = rfr && !m_lock && !rd_lock;
        if (apply) begin
            m_sub  = {16'b0, lv_sub};
            m_time = lv_time & 32'h007F_7F7F;
            m_date = lv_date & 32'h00FF_FF3F;
            m_flag = 1'b1;
        end else if (op == 5) begin
            m_flag = 1'b0;
        end
        if (rd_lock) m_lock = 1'b1;
        else if (rd_en && addr == 2'd2) m_lock = 1'b0;
        @(posedge clk);
        #1;
        refresh = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        if (tag != "") rtag = tag;
        else if (op == 1 || op == 2) rtag = "R5";
        else if (op == 3) rtag = "R6";
        else if (op == 4) rtag = "R10";
        else if (op >= 7) rtag = "R9";
        else rtag = "R2";
        ftag = (op == 5 || op == 6) ? "R8" : (rfr ? "R7" : "R3");
        chk(rtag, rdata, m_rd);
        chk(ftag, {31'b0, sync_flag}, {31'b0, m_flag});
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        wd++;
        if (wd == 150000) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", rdata, 32'h0);
        chk("R1", {31'b0, sync_flag}, 32'h0);
        step(4, 0, "R1");                 // status after reset is zero
        step(1, 0, "R1");                 // sub-second copy zero
        step(3, 0, "R1");                 // date copy zero, thaw
        all_ones = 1'b1;
        step(0, 1, "R3");                 // load all three copies
        all_ones = 1'b0;
        step(1, 0, "R3");                 // sub-second zero-extended
        step(2, 1, "R4");                 // time mask; refresh blocked
        step(3, 0, "R4");                 // date mask, thaw
        step(7, 0, "R9");
        step(8, 0, "R9");
        step(2, 0, "R9");                 // time still the all-ones mask
        step(3, 0, "R6");
        step(0, 1, "R6");                 // refresh after thaw applies
        step(5, 1, "R8");                 // refresh wins over clear
        step(5, 0, "R8");
        step(4, 0, "R10");
        // exhaustive three-cycle sweep of operations and refresh
        for (int a = 0; a < 18; a++)
            for (int b = 0; b < 18; b++)
                for (int c = 0; c < 18; c++) begin
                    step(a / 2, bit'(a % 2), "");
                    step(b / 2, bit'(b % 2), "");
                    step(c / 2, bit'(c % 2), "");
                end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule